// File: doc/BRIEF.md
# Twelve-Bit Multi-Mode Counter Timer

This peripheral is a 12-bit up-counter with four run modes chosen by a control field: interval timing on prescaler ticks, counting of rising edges on an external input, measurement of how long that input stays high, and generation of a square wave on a dedicated output. The counter wraps from its all-ones value, reloads from a software-written reload register, and raises a single-cycle interrupt request on each wrap.

The external input is shared with an interrupt request pin elsewhere in the chip, so it arrives asynchronously and passes through a two-flop synchronizer before any edge is taken from it. The timer is clocked from the system clock and advances on a one-cycle tick supplied by an external prescaler. The CPU side consists of two write strobes, one for the reload value and one for the mode and run bits, plus read-only views of the count, the capture register and the control state. On reset, and on the pulse that marks the end of the low-power hold state, the counter is forced to 0xFFC, so the first wrap comes four advances later.

Top module: `tmr12_multi`

## Requirements
- R1: After reset the count reads 0xFFC, the capture register reads 0x000, the square-wave output and the interrupt request are low, the timer is stopped and the mode field reads 0 (interval).
- R2: A one-cycle pulse on `hold_exit_i` loads 0xFFC into the count on the next clock edge, whether the timer is running or stopped, and overrides any advance or wrap in that cycle.
- R3: In interval mode (mode code 0) with the run bit set, the count increases by one on each clock edge at which `tick_i` is high, and holds otherwise.
- R4: An advance from 0xFFF loads the count with the reload register and drives `irq_o` high for exactly the one following cycle.
- R5: In event mode (mode code 1) the count increases by one for each rising edge of `evt_pin_i` seen after a two-flop synchronizer; `tick_i` has no effect on the count in this mode.
- R6: In pulse-width mode (mode code 2) the count advances on `tick_i` only while the synchronized input is high, and on each falling edge of the synchronized input the current count is copied into `capture_o`.
- R7: In square-wave mode (mode code 3) the count advances on `tick_i` and `sq_o` toggles on every wrap; in the other modes `sq_o` keeps its value across wraps.
- R8: A write to the control register (`wr_ctrl_i`) always loads the run bit, but loads the mode field only if the timer was stopped before that write; a mode written while running is discarded.
- R9: While the run bit is clear, the count holds its value regardless of `tick_i` and `evt_pin_i`, except for the load of R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | One-cycle advance tick from the prescaler |
| evt_pin_i | input | 1 | Asynchronous external event / pulse input |
| hold_exit_i | input | 1 | One-cycle pulse when hold state ends |
| wr_reload_i | input | 1 | Write strobe for the reload register |
| reload_data_i | input | 12 | Reload value to write |
| wr_ctrl_i | input | 1 | Write strobe for the control register |
| ctrl_mode_i | input | 2 | Mode to write: 0 interval, 1 event, 2 pulse width, 3 square wave |
| ctrl_run_i | input | 1 | Run bit to write |
| count_o | output | 12 | Current count |
| capture_o | output | 12 | Count captured at the last falling edge in pulse-width mode |
| mode_o | output | 2 | Current mode field |
| run_o | output | 1 | Current run bit |
| sq_o | output | 1 | Square-wave output |
| irq_o | output | 1 | Single-cycle wrap interrupt request |

## Verification
The embedded assertions watch, on every cycle, that a stopped timer keeps its count, that the hold-exit pulse always lands on 0xFFC, that each interrupt request follows a count of 0xFFF, that the square-wave output only moves together with an interrupt request, and that the mode field never changes while running. Only the bench scenarios can show the counting itself: the per-tick and per-edge increments in each mode, the reload value that appears after a wrap, the captured pulse width, the toggle sequence of the square wave and the discarding of a mode write made while running.

// File: rtl/tmr12_pkg.sv
package tmr12_pkg;

  typedef enum logic [1:0] {
    MODE_INTERVAL = 2'd0,
    MODE_EVENT    = 2'd1,
    MODE_PULSE    = 2'd2,
    MODE_SQUARE   = 2'd3
  } tmr_mode_e;

endpackage

// File: rtl/tmr12_sync_edge.sv
module tmr12_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;
  logic              prev_q;

  always_comb begin
    chain_d[0] = pin_i;
  end

  generate
    for (genvar g = 1; g < STAGES; g++) begin : g_stage
      always_comb chain_d[g] = chain_q[g-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= chain_d;
      prev_q  <= chain_q[STAGES-1];
    end
  end

  always_comb begin
    level_o = chain_q[STAGES-1];
    rise_o  = chain_q[STAGES-1] & ~prev_q;
    fall_o  = ~chain_q[STAGES-1] & prev_q;
  end

endmodule

// File: rtl/tmr12_ctrl.sv
module tmr12_ctrl
  import tmr12_pkg::*;
#(
  parameter int unsigned WIDTH = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_reload_i,
  input  logic [WIDTH-1:0] reload_data_i,
  input  logic             wr_ctrl_i,
  input  tmr_mode_e        ctrl_mode_i,
  input  logic             ctrl_run_i,
  output tmr_mode_e        mode_o,
  output logic             run_o,
  output logic [WIDTH-1:0] reload_o
);

  tmr_mode_e        mode_q, mode_d;
  logic             run_q, run_d;
  logic [WIDTH-1:0] reload_q, reload_d;
  logic             mode_en;

  always_comb begin
    mode_en  = wr_ctrl_i & ~run_q;
    mode_d   = mode_en ? ctrl_mode_i : mode_q;
    run_d    = wr_ctrl_i ? ctrl_run_i : run_q;
    reload_d = wr_reload_i ? reload_data_i : reload_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= MODE_INTERVAL;
      run_q    <= 1'b0;
      reload_q <= '0;
    end else begin
      mode_q   <= mode_d;
      run_q    <= run_d;
      reload_q <= reload_d;
    end
  end

  assign mode_o   = mode_q;
  assign run_o    = run_q;
  assign reload_o = reload_q;

  // R8: mode field is locked while the timer runs
  assert_mode_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |=> $stable(mode_q));

endmodule

// File: rtl/tmr12_core.sv
module tmr12_core
  import tmr12_pkg::*;
#(
  parameter int unsigned WIDTH    = 12,
  parameter int unsigned INIT_VAL = 'hFFC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tmr_mode_e        mode_i,
  input  logic             run_i,
  input  logic [WIDTH-1:0] reload_i,
  input  logic             tick_i,
  input  logic             level_i,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic             hold_exit_i,
  output logic [WIDTH-1:0] count_o,
  output logic [WIDTH-1:0] capture_o,
  output logic             sq_o,
  output logic             irq_o
);

  localparam logic [WIDTH-1:0] CNT_MAX  = '1;
  localparam logic [WIDTH-1:0] CNT_INIT = WIDTH'(INIT_VAL);

  logic [WIDTH-1:0] cnt_q, cnt_d;
  logic [WIDTH-1:0] cap_q, cap_d;
  logic             sq_q, sq_d;
  logic             irq_q, irq_d;
  logic             adv;
  logic             wrap;
  logic             cap_en;

  // advance enable per mode
  always_comb begin
    unique case (mode_i)
      MODE_INTERVAL: adv = tick_i;
      MODE_EVENT:    adv = rise_i;
      MODE_PULSE:    adv = tick_i & level_i;
      MODE_SQUARE:   adv = tick_i;
      default:       adv = 1'b0;
    endcase
    adv    = adv & run_i;
    wrap   = adv & (cnt_q == CNT_MAX) & ~hold_exit_i;
    cap_en = run_i & fall_i & (mode_i == MODE_PULSE);
  end

  // next state
  always_comb begin
    if (hold_exit_i)   cnt_d = CNT_INIT;
    else if (wrap)     cnt_d = reload_i;
    else if (adv)      cnt_d = cnt_q + 1'b1;
    else               cnt_d = cnt_q;
    cap_d = cap_en ? cnt_q : cap_q;
    irq_d = wrap;
    sq_d  = (wrap && mode_i == MODE_SQUARE) ? ~sq_q : sq_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CNT_INIT;
      cap_q <= '0;
      sq_q  <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      cap_q <= cap_d;
      sq_q  <= sq_d;
      irq_q <= irq_d;
    end
  end

  assign count_o   = cnt_q;
  assign capture_o = cap_q;
  assign sq_o      = sq_q;
  assign irq_o     = irq_q;

  // R9: a stopped timer keeps its count unless hold exit loads it
  assert_count_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !hold_exit_i) |=> $stable(cnt_q));

  // R2: hold exit always lands on the initial value
  assert_hold_init_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hold_exit_i |=> (cnt_q == CNT_INIT));

  // R4: an interrupt request follows a count at the top value
  assert_wrap_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> ($past(cnt_q) == CNT_MAX));

  // R7: the square output moves only together with a wrap request
  assert_sq_only_on_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sq_q) |-> irq_q);

endmodule

// File: rtl/tmr12_multi.sv
module tmr12_multi
  import tmr12_pkg::*;
#(
  parameter int unsigned WIDTH       = 12,
  parameter int unsigned INIT_VAL    = 'hFFC,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             evt_pin_i,
  input  logic             hold_exit_i,
  input  logic             wr_reload_i,
  input  logic [WIDTH-1:0] reload_data_i,
  input  logic             wr_ctrl_i,
  input  logic [1:0]       ctrl_mode_i,
  input  logic             ctrl_run_i,
  output logic [WIDTH-1:0] count_o,
  output logic [WIDTH-1:0] capture_o,
  output logic [1:0]       mode_o,
  output logic             run_o,
  output logic             sq_o,
  output logic             irq_o
);

  // reset: asserted asynchronously, released on the clock
  logic [RST_STAGES-1:0] rst_pipe_q;
  logic                  rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[RST_STAGES-1];

  tmr_mode_e        mode_w;
  logic             run_w;
  logic [WIDTH-1:0] reload_w;
  logic             lvl_w, rise_w, fall_w;

  tmr12_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .wr_reload_i   (wr_reload_i),
    .reload_data_i (reload_data_i),
    .wr_ctrl_i     (wr_ctrl_i),
    .ctrl_mode_i   (tmr_mode_e'(ctrl_mode_i)),
    .ctrl_run_i    (ctrl_run_i),
    .mode_o        (mode_w),
    .run_o         (run_w),
    .reload_o      (reload_w)
  );

  tmr12_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .pin_i   (evt_pin_i),
    .level_o (lvl_w),
    .rise_o  (rise_w),
    .fall_o  (fall_w)
  );

  tmr12_core #(.WIDTH(WIDTH), .INIT_VAL(INIT_VAL)) u_core (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .mode_i      (mode_w),
    .run_i       (run_w),
    .reload_i    (reload_w),
    .tick_i      (tick_i),
    .level_i     (lvl_w),
    .rise_i      (rise_w),
    .fall_i      (fall_w),
    .hold_exit_i (hold_exit_i),
    .count_o     (count_o),
    .capture_o   (capture_o),
    .sq_o        (sq_o),
    .irq_o       (irq_o)
  );

  assign mode_o = mode_w;
  assign run_o  = run_w;

endmodule

// File: tb/tb_tmr12_multi.sv
module tb_tmr12_multi;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick_i, evt_pin_i, hold_exit_i;
  logic        wr_reload_i, wr_ctrl_i, ctrl_run_i;
  logic [11:0] reload_data_i;
  logic [1:0]  ctrl_mode_i;
  logic [11:0] count_o, capture_o;
  logic [1:0]  mode_o;
  logic        run_o, sq_o, irq_o;

  always #5 clk = ~clk;

  tmr12_multi dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .evt_pin_i(evt_pin_i),
    .hold_exit_i(hold_exit_i), .wr_reload_i(wr_reload_i),
    .reload_data_i(reload_data_i), .wr_ctrl_i(wr_ctrl_i),
    .ctrl_mode_i(ctrl_mode_i), .ctrl_run_i(ctrl_run_i),
    .count_o(count_o), .capture_o(capture_o), .mode_o(mode_o),
    .run_o(run_o), .sq_o(sq_o), .irq_o(irq_o)
  );

  // scoreboard item: which output, expected value, requirement tag
  typedef struct {
    int          kind;   // 0 count 1 capture 2 sq 3 irq 4 mode 5 run
    logic [11:0] exp;
    string       req;
  } sb_item_t;

  sb_item_t sb_q[$];
  event     smp_ev;
  int       n_checks = 0;
  int       n_errors = 0;
  bit       done = 1'b0;

  // monitor: pops expected items and compares with the ports
  initial begin
    forever begin
      @(smp_ev);
      while (sb_q.size() > 0) begin
        sb_item_t it;
        logic [11:0] act;
        it = sb_q.pop_front();
        case (it.kind)
          0: act = count_o;
          1: act = capture_o;
          2: act = {11'd0, sq_o};
          3: act = {11'd0, irq_o};
          4: act = {10'd0, mode_o};
          default: act = {11'd0, run_o};
        endcase
        n_checks++;
        if (act !== it.exp) begin
          n_errors++;
          $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
        end
      end
    end
  end

  task automatic expect_val(input int kind, input logic [11:0] exp, input string req);
    sb_item_t it;
    it.kind = kind; it.exp = exp; it.req = req;
    sb_q.push_back(it);
    -> smp_ev;
    #1;
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      tick_i = 1'b1; step(1); tick_i = 1'b0;
    end
  endtask

  task automatic wr_ctrl(input logic [1:0] m, input logic r);
    wr_ctrl_i = 1'b1; ctrl_mode_i = m; ctrl_run_i = r;
    step(1);
    wr_ctrl_i = 1'b0;
  endtask

  task automatic wr_reload(input logic [11:0] v);
    wr_reload_i = 1'b1; reload_data_i = v;
    step(1);
    wr_reload_i = 1'b0;
  endtask

  task automatic hold_pulse();
    hold_exit_i = 1'b1; step(1); hold_exit_i = 1'b0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_errors++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    rst_n = 1'b0; tick_i = 0; evt_pin_i = 0; hold_exit_i = 0;
    wr_reload_i = 0; wr_ctrl_i = 0; ctrl_run_i = 0;
    reload_data_i = '0; ctrl_mode_i = '0;
    step(4);
    rst_n = 1'b1;
    step(4);

    // R1 reset state
    expect_val(0, 12'hFFC, "R1");
    expect_val(1, 12'h000, "R1");
    expect_val(2, 12'h0,   "R1");
    expect_val(3, 12'h0,   "R1");
    expect_val(4, 12'h0,   "R1");
    expect_val(5, 12'h0,   "R1");

    // R3 interval counting
    wr_reload(12'h100);
    wr_ctrl(2'd0, 1'b1);
    tick(2);
    expect_val(0, 12'hFFE, "R3");
    step(3);
    expect_val(0, 12'hFFE, "R3");
    tick(1);
    expect_val(0, 12'hFFF, "R3");

    // R4 wrap, reload and single-cycle request
    tick(1);
    expect_val(0, 12'h100, "R4");
    expect_val(3, 12'h1,   "R4");
    step(1);
    expect_val(3, 12'h0,   "R4");
    expect_val(2, 12'h0,   "R7");

    // R8 mode write while running is dropped; run bit still applies
    wr_ctrl(2'd1, 1'b0);
    expect_val(4, 12'h0, "R8");
    expect_val(5, 12'h0, "R8");

    // R9 stopped count holds
    tick(3);
    evt_pin_i = 1'b1; step(4); evt_pin_i = 1'b0; step(4);
    expect_val(0, 12'h100, "R9");

    // R2 hold exit while stopped
    hold_pulse();
    expect_val(0, 12'hFFC, "R2");

    // R5 event mode
    wr_ctrl(2'd1, 1'b1);
    expect_val(4, 12'h1, "R8");
    for (int k = 0; k < 2; k++) begin
      evt_pin_i = 1'b1; step(4);
      evt_pin_i = 1'b0; step(4);
    end
    expect_val(0, 12'hFFE, "R5");
    tick(3);
    expect_val(0, 12'hFFE, "R5");

    // R6 pulse-width mode
    wr_ctrl(2'd1, 1'b0);
    wr_ctrl(2'd2, 1'b1);
    wr_reload(12'h020);
    hold_pulse();
    expect_val(0, 12'hFFC, "R2");
    evt_pin_i = 1'b1; step(3);
    tick(3);
    expect_val(0, 12'hFFF, "R6");
    evt_pin_i = 1'b0; step(4);
    expect_val(1, 12'hFFF, "R6");
    tick(2);
    expect_val(0, 12'hFFF, "R6");
    evt_pin_i = 1'b1; step(3);
    tick(1);
    expect_val(0, 12'h020, "R6");
    expect_val(2, 12'h0,   "R7");

    // R2 hold exit overrides an advance while running
    tick_i = 1'b1; hold_exit_i = 1'b1; step(1); tick_i = 1'b0; hold_exit_i = 1'b0;
    expect_val(0, 12'hFFC, "R2");
    evt_pin_i = 1'b0; step(4);

    // R7 square-wave mode
    wr_ctrl(2'd2, 1'b0);
    wr_ctrl(2'd3, 1'b1);
    wr_reload(12'hFFE);
    expect_val(4, 12'h3, "R8");
    tick(3);
    expect_val(0, 12'hFFF, "R7");
    expect_val(2, 12'h0,   "R7");
    tick(1);
    expect_val(0, 12'hFFE, "R7");
    expect_val(2, 12'h1,   "R7");
    tick(2);
    expect_val(0, 12'hFFE, "R7");
    expect_val(2, 12'h0,   "R7");
    tick(2);
    expect_val(2, 12'h1,   "R7");

    done = 1'b1;
    step(2);
    summary();
  end

endmodule